// File: doc/BRIEF.md
# CPU Halt and Interrupt Control Unit

This unit carries out the processor-control instructions of an 8-bit CPU core. These are the idle operation, the halt, the interrupt disable and enable pair, and the two-byte selection of interrupt mode 0. It holds the two interrupt-enable flip-flops, the interrupt-mode register and the halted state. From these it decides, at each instruction boundary, whether a pending maskable interrupt request may be taken.

The fetch sequencer presents every opcode byte it fetches with `opStrobe`. After the last byte of each instruction it raises `instEnd` for one cycle. The unit remembers an 0xED prefix internally, so the byte that follows the prefix is never decoded as a one-byte instruction. While the core is halted, the sequencer keeps running dummy opcode fetches from the address after the halt opcode, so that refresh continues. The unit ignores those bytes. When an interrupt is taken during the halt, `haltRelease` tells the sequencer to step the program counter past the halt opcode.

An enable does not open the interrupt window at once. The boundary that ends the enable instruction itself is still blocked, so the earliest point at which an interrupt can be taken is the end of the instruction that follows it.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset, both enable flags read 0, the interrupt mode reads 0, the halt status is low and no interrupt is taken.
- R2: A one-byte 0xF3 (disable) clears both enable flags from the next cycle on, and interrupts are not taken at any later boundary until they are enabled again.
- R3: A one-byte 0xFB (enable) sets both enable flags from the next cycle on.
- R4: After 0xFB, a request is refused at the boundary that ends the 0xFB instruction, and can be taken at the boundary that ends the next instruction.
- R5: `intTake` is high only in a cycle where `instEnd` and `intReq` are high, enable flag 1 is set and no enable delay is pending.
- R6: Taking an interrupt clears both enable flags from the next cycle on.
- R7: A one-byte 0x76 (halt) raises `haltStat` in the next cycle. Every byte presented while halted is ignored, so the enable flags and the mode stay as they were.
- R8: The halted state ends only when an interrupt is taken. In that cycle `haltRelease` is high, and `haltStat` is low from the next cycle on.
- R9: The byte pair 0xED, 0x46 sets the interrupt mode to 0. A byte that follows 0xED is never decoded as 0xF3, 0xFB, 0x76 or 0x00.
- R10: 0x00 (no operation), and any byte that is not one of the control opcodes, leaves the enable flags, the halt status and the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opStrobe | input | 1 | An opcode byte is presented this cycle |
| opByte | input | 8 | Opcode byte |
| instEnd | input | 1 | Instruction boundary; interrupts are sampled here |
| intReq | input | 1 | Maskable interrupt request (level) |
| intTake | output | 1 | Maskable interrupt accepted at this boundary |
| haltRelease | output | 1 | Halt ends now; step PC past the halt opcode |
| haltStat | output | 1 | Core is halted and running dummy fetches |
| iff1Out | output | 1 | Enable flag 1 (gates acceptance) |
| iff2Out | output | 1 | Enable flag 2 (saved copy) |
| intMode | output | 2 | Interrupt mode register |

## Verification
The properties take for granted that `opStrobe` and `instEnd` are never high in the same cycle. They also assume that a prefix byte 0xED is always followed by its second byte before the boundary. The stimulus builds every instruction as one or two byte strobes followed by a single boundary cycle, and while halted it issues only one dummy byte strobe per boundary. The checker follows the prefix by itself, so it can tell a real one-byte opcode from the second byte of a pair.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int OP_W   = 8;
  localparam int MODE_W = 2;

  localparam logic [OP_W-1:0] OP_IDLE  = 8'h00;
  localparam logic [OP_W-1:0] OP_HALT  = 8'h76;
  localparam logic [OP_W-1:0] OP_DIS   = 8'hF3;
  localparam logic [OP_W-1:0] OP_ENA   = 8'hFB;
  localparam logic [OP_W-1:0] OP_PFX   = 8'hED;
  localparam logic [OP_W-1:0] OP_MODE0 = 8'h46;

  localparam logic [MODE_W-1:0] MODE_ZERO = '0;

  typedef struct packed {
    logic              setIff;
    logic              clrIff;
    logic              setBlk;
    logic              clrBlk;
    logic              setHalt;
    logic              clrHalt;
    logic              setPfx;
    logic              clrPfx;
    logic              wrMode;
    logic [MODE_W-1:0] modeVal;
  } ctlStb_t;
endpackage

// File: rtl/irq_ctl_decode.sv
module irq_ctl_decode
  import irq_ctl_pkg::*;
(
  input  logic            opStrobe,
  input  logic [OP_W-1:0] opByte,
  input  logic            instEnd,
  input  logic            intReq,
  input  logic            iff1,
  input  logic            eiBlk,
  input  logic            halted,
  input  logic            pfxPend,
  output ctlStb_t         stb,
  output logic            intTake,
  output logic            haltRelease
);
  logic baseByte;
  logic pfxByte;
  logic isHalt, isDis, isEna, isPfx;

  assign baseByte = opStrobe && !halted && !pfxPend;
  assign pfxByte  = opStrobe && !halted && pfxPend;

  always_comb begin
    isHalt = 1'b0;
    isDis  = 1'b0;
    isEna  = 1'b0;
    isPfx  = 1'b0;
    unique case (opByte)
      OP_HALT: isHalt = 1'b1;
      OP_DIS:  isDis  = 1'b1;
      OP_ENA:  isEna  = 1'b1;
      OP_PFX:  isPfx  = 1'b1;
      default: ;
    endcase
  end

  assign intTake     = instEnd && intReq && iff1 && !eiBlk;
  assign haltRelease = intTake && halted;

  always_comb begin
    stb         = '0;
    stb.setIff  = baseByte && isEna;
    stb.clrIff  = (baseByte && isDis) || intTake;
    stb.setBlk  = baseByte && isEna;
    stb.clrBlk  = (instEnd && eiBlk) || (baseByte && isDis);
    stb.setHalt = baseByte && isHalt;
    stb.clrHalt = haltRelease;
    stb.setPfx  = baseByte && isPfx;
    stb.clrPfx  = pfxByte;
    stb.wrMode  = pfxByte && (opByte == OP_MODE0);
    stb.modeVal = MODE_ZERO;
  end
endmodule

// File: rtl/irq_ctl_state.sv
module irq_ctl_state
  import irq_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStb_t           stb,
  output logic              iff1,
  output logic              iff2,
  output logic              eiBlk,
  output logic              halted,
  output logic              pfxPend,
  output logic [MODE_W-1:0] intMode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iff1    <= 1'b0;
      iff2    <= 1'b0;
      eiBlk   <= 1'b0;
      halted  <= 1'b0;
      pfxPend <= 1'b0;
      intMode <= MODE_ZERO;
    end else begin
      if (stb.clrIff) begin
        iff1 <= 1'b0;
        iff2 <= 1'b0;
      end else if (stb.setIff) begin
        iff1 <= 1'b1;
        iff2 <= 1'b1;
      end

      if (stb.clrBlk)      eiBlk <= 1'b0;
      else if (stb.setBlk) eiBlk <= 1'b1;

      if (stb.clrHalt)      halted <= 1'b0;
      else if (stb.setHalt) halted <= 1'b1;

      if (stb.clrPfx)      pfxPend <= 1'b0;
      else if (stb.setPfx) pfxPend <= 1'b1;

      if (stb.wrMode) intMode <= stb.modeVal;
    end
  end
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opStrobe,
  input  logic [OP_W-1:0]   opByte,
  input  logic              instEnd,
  input  logic              intReq,
  output logic              intTake,
  output logic              haltRelease,
  output logic              haltStat,
  output logic              iff1Out,
  output logic              iff2Out,
  output logic [MODE_W-1:0] intMode
);
  ctlStb_t stb;
  logic iff1, iff2, eiBlk, halted, pfxPend;

  irq_ctl_decode u_dec (
    .opStrobe   (opStrobe),
    .opByte     (opByte),
    .instEnd    (instEnd),
    .intReq     (intReq),
    .iff1       (iff1),
    .eiBlk      (eiBlk),
    .halted     (halted),
    .pfxPend    (pfxPend),
    .stb        (stb),
    .intTake    (intTake),
    .haltRelease(haltRelease)
  );

  irq_ctl_state u_st (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .iff1   (iff1),
    .iff2   (iff2),
    .eiBlk  (eiBlk),
    .halted (halted),
    .pfxPend(pfxPend),
    .intMode(intMode)
  );

  assign haltStat = halted;
  assign iff1Out  = iff1;
  assign iff2Out  = iff2;
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk
  import irq_ctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              opStrobe,
  input logic [OP_W-1:0]   opByte,
  input logic              instEnd,
  input logic              intReq,
  input logic              intTake,
  input logic              haltRelease,
  input logic              haltStat,
  input logic              iff1Out,
  input logic              iff2Out,
  input logic [MODE_W-1:0] intMode
);
  logic afterPfx;
  logic realOp;

  always_ff @(posedge clk) begin
    if (!rst_n) afterPfx <= 1'b0;
    else if (opStrobe && !haltStat) afterPfx <= !afterPfx && (opByte == OP_PFX);
  end

  assign realOp = opStrobe && !haltStat && !afterPfx;

  // R5
  take_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intTake |-> (instEnd && intReq && iff1Out));

  // R2
  dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (realOp && opByte == OP_DIS) |=> (!iff1Out && !iff2Out));

  // R3
  ena_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (realOp && opByte == OP_ENA) |=> (iff1Out && iff2Out));

  // R4
  ena_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (realOp && opByte == OP_ENA) |=> !intTake);

  // R6
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intTake |=> (!iff1Out && !iff2Out));

  // R7
  halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (realOp && opByte == OP_HALT) |=> haltStat);

  // R7
  halt_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (haltStat && !intTake) |=> ($stable(iff1Out) && $stable(iff2Out) && $stable(intMode)));

  // R8
  halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (haltStat && intTake) |=> !haltStat);

  // R8
  release_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    haltRelease |-> (intTake && haltStat));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (realOp && opByte == OP_IDLE) |=> ($stable(iff1Out) && $stable(haltStat) && $stable(intMode)));
endmodule

bind irq_ctl_top irq_ctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .opStrobe   (opStrobe),
  .opByte     (opByte),
  .instEnd    (instEnd),
  .intReq     (intReq),
  .intTake    (intTake),
  .haltRelease(haltRelease),
  .haltStat   (haltStat),
  .iff1Out    (iff1Out),
  .iff2Out    (iff2Out),
  .intMode    (intMode)
);

// File: tb/irq_ctl_top_tb_top.sv
`timescale 1ns/1ps
module irq_ctl_top_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, opStrobe, instEnd, intReq;
  logic [7:0] opByte;
  logic       intTake, haltRelease, haltStat, iff1Out, iff2Out;
  logic [1:0] intMode;

  irq_ctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .opStrobe(opStrobe), .opByte(opByte),
    .instEnd(instEnd), .intReq(intReq), .intTake(intTake),
    .haltRelease(haltRelease), .haltStat(haltStat), .iff1Out(iff1Out),
    .iff2Out(iff2Out), .intMode(intMode)
  );

  int nVec = 0;
  int nBad = 0;
  string phase = "random";
  logic mIff1, mIff2, mBlk, mHalt, mPfx;
  logic [1:0] mMode;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase, act, exp);
    end
  endtask

  function automatic logic expTake(input logic e, input logic r);
    return e & r & mIff1 & !mBlk;
  endfunction

  task automatic cyc(input logic s, input logic [7:0] b, input logic e, input logic r);
    logic tk;
    logic base;
    logic pre;
    @(negedge clk);
    opStrobe = s; opByte = b; instEnd = e; intReq = r;
    #1;
    tk = expTake(e, r);
    chk("R5 intTake", {7'd0, intTake}, {7'd0, tk});
    chk("R8 haltRelease", {7'd0, haltRelease}, {7'd0, tk & mHalt});
    chk("R7 haltStat", {7'd0, haltStat}, {7'd0, mHalt});
    chk("R3 iff1", {7'd0, iff1Out}, {7'd0, mIff1});
    chk("R2 iff2", {7'd0, iff2Out}, {7'd0, mIff2});
    chk("R9 intMode", {6'd0, intMode}, {6'd0, mMode});
    base = s & !mHalt & !mPfx;
    pre  = s & !mHalt & mPfx;
    if (tk) begin mIff1 = 0; mIff2 = 0; mHalt = 0; end
    if (e && mBlk) mBlk = 0;
    if (base) begin
      case (b)
        8'hF3: begin mIff1 = 0; mIff2 = 0; mBlk = 0; end
        8'hFB: begin mIff1 = 1; mIff2 = 1; mBlk = 1; end
        8'h76: mHalt = 1;
        8'hED: mPfx = 1;
        default: ;
      endcase
    end
    if (pre) begin
      mPfx = 0;
      if (b == 8'h46) mMode = 2'd0;
    end
  endtask

  task automatic ins1(input logic [7:0] b, input logic r);
    cyc(1'b1, b, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, r);
  endtask

  task automatic ins2(input logic [7:0] b2, input logic r);
    cyc(1'b1, 8'hED, 1'b0, 1'b0);
    cyc(1'b1, b2, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, r);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 0; opStrobe = 0; opByte = 0; instEnd = 0; intReq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mIff1 = 0; mIff2 = 0; mBlk = 0; mHalt = 0; mPfx = 0; mMode = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired [%s] actual=running expected=done", phase);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    doReset();
    phase = "R1 reset state";
    cyc(1'b0, 8'h00, 1'b1, 1'b1);   // R1: request at a boundary after reset is refused

    phase = "R4 enable shadow";
    ins1(8'hFB, 1'b1);              // R3 sets flags, R4 refused at the enable's own boundary
    ins1(8'h00, 1'b1);              // R4 taken here; R6 clears the flags
    phase = "R6 flags cleared after take";
    cyc(1'b0, 8'h00, 1'b1, 1'b1);

    phase = "R9 prefixed byte not decoded";
    ins1(8'hFB, 1'b0);
    ins2(8'hF3, 1'b0);              // flags must stay set
    ins2(8'h46, 1'b0);              // R9 mode 0
    phase = "R10 idle and unknown bytes";
    ins1(8'h00, 1'b0);
    ins1(8'h3C, 1'b0);

    phase = "R7 halt with ignored dummies";
    ins1(8'h76, 1'b0);
    ins1(8'hF3, 1'b0);              // dummy fetch while halted: no disable
    ins1(8'hED, 1'b0);
    ins1(8'h76, 1'b0);
    phase = "R8 halt release";
    ins1(8'h00, 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0);

    phase = "R2 disable blocks";
    ins1(8'hFB, 1'b0);
    ins1(8'h00, 1'b0);
    ins1(8'hF3, 1'b1);
    ins1(8'h00, 1'b1);

    phase = "random";
    for (int i = 0; i < 3000; i++) begin
      int pick;
      logic r;
      pick = $urandom_range(0, 9);
      r = ($urandom_range(0, 2) == 0);
      if (mHalt) ins1(8'($urandom_range(0, 255)), r);
      else begin
        case (pick)
          0: ins1(8'h00, r);
          1: ins1(8'h76, r);
          2, 3: ins1(8'hF3, r);
          4, 5: ins1(8'hFB, r);
          6: ins2(8'h46, r);
          7: ins2(8'($urandom_range(0, 255)), r);
          8: cyc(1'b0, 8'h00, 1'b0, r);
          default: begin
            logic [7:0] rb;
            rb = 8'($urandom_range(0, 255));
            if (rb == 8'hED) rb = 8'h01;
            ins1(rb, r);
          end
        endcase
      end
    end

    summary();
    $finish;
  end
endmodule